// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block turns an asynchronous serial line into bytes. A one-clock `tick` pulse arrives sixteen times per bit period. The block uses it to find a start bit, confirm the start bit, and sample each following bit at its centre. Finished characters go into a sixteen-entry queue. The parity check result for each character is stored next to it.

The character format comes from the six low bits of the line-control byte that the transmitter also uses. The two highest bits of that byte control transmit-only features and are not connected. Software pops characters with `rdPop`. The `dataReady` flag shows that the queue has something to read. The `overrun` flag shows that a character was lost because the queue was full. `overrun` stays set until a status read (`stsRead`).

Top module: `uart_rx_top`

## Requirements
- R1: During reset and just after it, `dataReady`, `overrun`, `rdData` and `rdParErr` are all 0.
- R2: A low level on `serIn`, seen on a tick while idle, starts a candidate start bit. The candidate is accepted only if `serIn` is still low on the eighth tick after it. Otherwise the receiver goes back to idle and stores nothing.
- R3: Data bits are sampled every sixteen ticks after the accepted start centre and are assembled least significant bit first. `lineCtrl[1:0]` sets the length: 00=5, 01=6, 10=7, 11=8 bits. Stored bits above the length are 0.
- R4: `lineCtrl[3]=1` enables a parity bit after the data, checked according to `lineCtrl[5:4]`: 00 odd, 01 even, 10 always 1, 11 always 0. The stored `rdParErr` is 1 exactly when parity is enabled and the received parity bit differs from the expected one.
- R5: A character is finished at the centre of its first stop bit. With `lineCtrl[2]=1` the receiver also waits out a second stop bit before it looks for a new start. Characters are received correctly with either setting.
- R6: `dataReady` is 1 exactly while the queue holds at least one unread character, and 0 once it is empty.
- R7: The queue holds 16 characters in arrival order. A `rdPop` while not empty updates `rdData`/`rdParErr` on that clock edge to the oldest entry and removes it. With no pop, the outputs hold.
- R8: A `rdPop` while the queue is empty leaves `rdData`, `rdParErr` and `dataReady` unchanged.
- R9: A character finished while the queue is full sets `overrun` on that clock edge. That character is dropped and the queued contents are kept.
- R10: `overrun` stays set until a cycle with `stsRead` high clears it. If a new overrun occurs in the same cycle as `stsRead`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling pulse, 16 per bit period |
| serIn | input | 1 | Serial input, idles high |
| lineCtrl | input | 6 | Character format: [1:0] length, [2] two stop bits, [3] parity on, [5:4] parity kind |
| rdPop | input | 1 | Pop one character from the queue |
| stsRead | input | 1 | Status read; clears `overrun` |
| rdData | output | 8 | Last popped character |
| rdParErr | output | 1 | Parity mismatch flag stored with `rdData` |
| dataReady | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
The assertions take three things for granted. `lineCtrl` does not change while a character is being received. `tick` is a single-cycle pulse. `serIn` is already synchronous to `clk`. The bench meets all three. It changes the format only between characters, with the line idle. It makes `tick` one clock in four. It changes `serIn` only on falling clock edges, for whole multiples of sixteen ticks, except for the deliberately short false start. The set-over-clear case is reached by holding `stsRead` high across the overflowing character and releasing it on the clock after `overrun` rises.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2
  } rxStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic             start;    // clear the shift register
    logic             dataBit;  // capture serIn at bitIdx
    logic [IDX_W-1:0] bitIdx;
    logic             parBit;   // capture the parity sample
    logic             done;     // character finished
  } rxStrobeT;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      popData <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop) begin
        popData <= mem[rdPtr];
        rdPtr   <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       serIn,
  input  logic [1:0] lenSel,
  input  logic       parEn,
  input  logic       twoStop,
  output rxStrobeT   strb
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

  rxStateT          state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             midBit, midStart;

  assign lastIdx  = IDX_W'({1'b0, lenSel}) + IDX_W'(4);
  assign midBit   = tick && (tickCnt == FULL_LAST);
  assign midStart = tick && (tickCnt == HALF_LAST);

  always_comb begin
    strb        = '0;
    strb.bitIdx = bitIdx;
    unique case (state)
      ST_IDLE:  strb.start   = tick && !serIn;
      ST_DATA:  strb.dataBit = midBit;
      ST_PAR:   strb.parBit  = midBit;
      ST_STOP:  strb.done    = midBit;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      if (state != ST_IDLE && tick)
        tickCnt <= (tickCnt == FULL_LAST) ? '0 : tickCnt + 1'b1;
      unique case (state)
        ST_IDLE: if (tick && !serIn) begin
          state   <= ST_START;
          tickCnt <= '0;
        end
        ST_START: if (midStart) begin
          tickCnt <= '0;
          bitIdx  <= '0;
          state   <= serIn ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (midBit) begin
          if (bitIdx == lastIdx) state <= parEn ? ST_PAR : ST_STOP;
          else                   bitIdx <= bitIdx + 1'b1;
        end
        ST_PAR:   if (midBit) state <= ST_STOP;
        ST_STOP:  if (midBit) state <= twoStop ? ST_STOP2 : ST_IDLE;
        ST_STOP2: if (midBit) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              parEn,
  input  logic [1:0]        parSel,
  input  rxStrobeT          strb,
  input  logic              rdPop,
  input  logic              stsRead,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParErr,
  output logic              dataReady,
  output logic              overrun
);
  localparam int ENT_W = DATA_W + 1;

  logic [DATA_W-1:0] shiftReg;
  logic              parSample;
  logic              expPar, parErr;
  logic              fifoFull, fifoEmpty, ovEvent;
  logic [ENT_W-1:0]  popEnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parSample <= 1'b0;
    end else begin
      if (strb.start)   shiftReg <= '0;
      if (strb.dataBit) shiftReg[strb.bitIdx] <= serIn;
      if (strb.parBit)  parSample <= serIn;
    end
  end

  // Unused upper bits stay zero, so the full-width XOR is the data parity.
  always_comb begin
    unique case (parSel)
      2'b00: expPar = ~(^shiftReg);
      2'b01: expPar = ^shiftReg;
      2'b10: expPar = 1'b1;
      default: expPar = 1'b0;
    endcase
  end
  assign parErr = parEn && (parSample != expPar);

  uart_rx_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.done),
    .pushData ({parErr, shiftReg}),
    .pop      (rdPop),
    .popData  (popEnt),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  assign ovEvent   = strb.done && fifoFull;
  assign dataReady = !fifoEmpty;
  assign rdData    = popEnt[DATA_W-1:0];
  assign rdParErr  = popEnt[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        overrun <= 1'b0;
    else if (ovEvent) overrun <= 1'b1;
    else if (stsRead) overrun <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              serIn,
  input  logic [5:0]        lineCtrl,
  input  logic              rdPop,
  input  logic              stsRead,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParErr,
  output logic              dataReady,
  output logic              overrun
);
  rxStrobeT strb;

  uart_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .serIn   (serIn),
    .lenSel  (lineCtrl[1:0]),
    .parEn   (lineCtrl[3]),
    .twoStop (lineCtrl[2]),
    .strb    (strb)
  );

  uart_rx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serIn     (serIn),
    .parEn     (lineCtrl[3]),
    .parSel    (lineCtrl[5:4]),
    .strb      (strb),
    .rdPop     (rdPop),
    .stsRead   (stsRead),
    .rdData    (rdData),
    .rdParErr  (rdParErr),
    .dataReady (dataReady),
    .overrun   (overrun)
  );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rdPop,
  input logic       stsRead,
  input logic       chrDone,
  input logic [7:0] rdData,
  input logic       rdParErr,
  input logic       dataReady,
  input logic       overrun
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!overrun && !dataReady && rdData == 8'h00 && !rdParErr));

  // R6: queue becomes non-empty only when a character finishes
  a_r6_ready_from_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(chrDone));

  // R6: queue drains only through a pop
  a_r6_ready_falls_on_pop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReady) |-> $past(rdPop));

  // R7
  a_r7_hold_without_pop: assert property (@(posedge clk) disable iff (!rstN)
    !rdPop |=> ($stable(rdData) && $stable(rdParErr)));

  // R8
  a_r8_empty_pop_noop: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && !dataReady) |=> ($stable(rdData) && $stable(rdParErr)));

  // R9
  a_r9_overrun_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(chrDone) && $past(dataReady)));

  // R10
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !stsRead) |=> overrun);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stsRead && !chrDone) |=> !overrun);
endmodule

bind uart_rx_top uart_rx_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdPop     (rdPop),
  .stsRead   (stsRead),
  .chrDone   (strb.done),
  .rdData    (rdData),
  .rdParErr  (rdParErr),
  .dataReady (dataReady),
  .overrun   (overrun)
);

// File: tb/tb_uart_rx_top.sv
module tb_uart_rx_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;
  localparam int WDOG     = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       serIn = 1'b1;
  logic [5:0] lineCtrl = 6'h03;
  logic       rdPop = 1'b0;
  logic       stsRead = 1'b0;
  logic [7:0] rdData;
  logic       rdParErr, dataReady, overrun;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 1'b0;
  int divCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_rx_top dut (
    .clk(clk), .rstN(rstN), .tick(tick), .serIn(serIn), .lineCtrl(lineCtrl),
    .rdPop(rdPop), .stsRead(stsRead), .rdData(rdData), .rdParErr(rdParErr),
    .dataReady(dataReady), .overrun(overrun)
  );

  always @(negedge clk) begin
    divCnt <= (divCnt == TICK_DIV-1) ? 0 : divCnt + 1;
    tick   <= (divCnt == TICK_DIV-1);
  end

  typedef struct packed {
    logic [5:0] lcr;
    logic [7:0] data;
    logic       flip;
    logic [7:0] expData;
    logic       expErr;
  } vecT;

  localparam vecT VECS [8] = '{
    '{6'h03, 8'hA5, 1'b0, 8'hA5, 1'b0},  // 8 bits, no parity
    '{6'h1B, 8'h3C, 1'b0, 8'h3C, 1'b0},  // 8 bits, even
    '{6'h0A, 8'hFF, 1'b0, 8'h7F, 1'b0},  // 7 bits, odd, top bit masked
    '{6'h04, 8'hF5, 1'b0, 8'h15, 1'b0},  // 5 bits, two stops
    '{6'h29, 8'h2A, 1'b0, 8'h2A, 1'b0},  // 6 bits, forced 1
    '{6'h3B, 8'h81, 1'b1, 8'h81, 1'b1},  // 8 bits, forced 0, wrong parity
    '{6'h0B, 8'h00, 1'b1, 8'h00, 1'b1},  // 8 bits, odd, wrong parity
    '{6'h19, 8'h3F, 1'b0, 8'h3F, 1'b0}   // 6 bits, even
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    serIn = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic sendChar(input logic [5:0] lcr, input logic [7:0] data, input logic flip);
    int   len;
    logic [7:0] mask;
    logic ones, par;
    len  = int'(lcr[1:0]) + 5;
    mask = 8'((1 << len) - 1);
    ones = ^(data & mask);
    case (lcr[5:4])
      2'b00: par = ~ones;
      2'b01: par = ones;
      2'b10: par = 1'b1;
      default: par = 1'b0;
    endcase
    lineCtrl = lcr;
    holdBit(1'b0);
    for (int i = 0; i < len; i++) holdBit(data[i]);
    if (lcr[3]) holdBit(par ^ flip);
    holdBit(1'b1);
    if (lcr[2]) holdBit(1'b1);
    serIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic popOne();
    rdPop = 1'b1;
    @(negedge clk);
    rdPop = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish();
    end
  end

  initial begin
    logic [7:0] lastVal;
    bit sawRise;
    repeat (5) @(negedge clk);
    // R1: values while reset is held
    chk("R1 dataReady", 32'(dataReady), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 rdData", 32'(rdData), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rdParErr after reset", 32'(rdParErr), 0);

    // Table walk: R3, R4, R5, R6, R7
    foreach (VECS[i]) begin
      sendChar(VECS[i].lcr, VECS[i].data, VECS[i].flip);
      chk("R6 ready after char", 32'(dataReady), 1);
      popOne();
      chk("R3 R5 data", 32'(rdData), 32'(VECS[i].expData));
      chk("R4 parity flag", 32'(rdParErr), 32'(VECS[i].expErr));
      chk("R6 ready after drain", 32'(dataReady), 0);
    end

    // R2: short low pulse is rejected
    lineCtrl = 6'h03;
    serIn = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    serIn = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    chk("R2 false start stores nothing", 32'(dataReady), 0);
    sendChar(6'h03, 8'h5A, 1'b0);
    popOne();
    chk("R2 clean char after false start", 32'(rdData), 32'h5A);

    // R8: pop while empty
    lastVal = rdData;
    popOne();
    chk("R8 data unchanged", 32'(rdData), 32'(lastVal));
    chk("R8 still empty", 32'(dataReady), 0);

    // R9: fill and overflow
    for (int i = 0; i < 16; i++) sendChar(6'h03, 8'(8'h40 + i), 1'b0);
    chk("R9 no overrun at full", 32'(overrun), 0);
    sendChar(6'h03, 8'h99, 1'b0);
    chk("R9 overrun set", 32'(overrun), 1);
    repeat (200) @(negedge clk);
    chk("R10 overrun sticky", 32'(overrun), 1);
    stsRead = 1'b1;
    @(negedge clk);
    stsRead = 1'b0;
    chk("R10 read clears", 32'(overrun), 0);
    for (int i = 0; i < 16; i++) begin
      popOne();
      chk("R7 R9 order and contents", 32'(rdData), 32'(8'h40 + i));
    end
    chk("R6 empty after 16 pops", 32'(dataReady), 0);
    popOne();
    chk("R8 dropped char not present", 32'(rdData), 32'h4F);

    // R10: set wins over a simultaneous read
    for (int i = 0; i < 16; i++) sendChar(6'h03, 8'(8'h60 + i), 1'b0);
    stsRead = 1'b1;
    sawRise = 1'b0;
    fork
      sendChar(6'h03, 8'h77, 1'b0);
      begin
        for (int k = 0; k < 2000 && !overrun; k++) @(negedge clk);
        sawRise = overrun;
        stsRead = 1'b0;
      end
    join
    stsRead = 1'b0;
    chk("R10 set wins over read", 32'(sawRise), 1);
    chk("R10 still set afterwards", 32'(overrun), 1);
    popOne();
    chk("R9 oldest kept", 32'(rdData), 32'h60);

    finish();
  end
endmodule